// File: doc/BRIEF.md
# Overlapped Frame Input Buffer Controller

This block owns the sample store in front of a block transform engine. Each complex point takes two words, real then imaginary, so a frame of N points fills words 0 to 2N-1 of a 2K-word memory. In streaming (continuous) mode, incoming samples go to addresses the block generates itself. When a frame is complete, the block signals the engine and then moves the newest part of that frame down to the bottom of the memory. The size of that part is set by the overlap select. New samples then fill in directly above the moved region, so consecutive frames share data without the source having to send it twice.

In direct mode, a host places words anywhere through an addressed write port. The engine reads the memory through its own read port, which has one cycle of latency. Size, overlap and mode settings are sampled only at frame boundaries, so a frame in progress is never reshaped.

Top module: `ovl_in_buf`

## Requirements
- R1: While reset is held, full_n is 1, frame_rdy is 0 and s_ready is 0.
- R2: In continuous mode, each accepted sample (s_valid and s_ready both high at a rising edge) is stored at the next address, counting up from the fill start. A cycle with s_valid low stores nothing and does not advance the address.
- R3: frame_rdy is high for exactly one cycle, starting the cycle after the 2N-th word of a frame is written. N is set by size_sel: 00=16, 01=64, 10=256, 11=1024 points, which is 32, 128, 512 or 2048 words.
- R4: After a continuous frame completes with the size unchanged, its top K words (frame words 2N-K to 2N-1) are copied in ascending order to addresses 0 to K-1. K is set by ovl_sel as a fraction of 2N: 00=0, 01=1/4, 10=1/2, 11=3/4. The next sample is then stored at address K. For example, with 1024 points and 01, words 0x600-0x7FF move to 0x000-0x1FF and filling resumes at 0x200.
- R5: After a continuous frame completes, full_n is 0 and s_ready is 0 for K+1 cycles, starting in the frame_rdy cycle. A sample held by the source during that time is accepted later and is not lost.
- R6: In direct mode, a rising edge with wr_n low stores wr_data at wr_addr. A write to word 2N-1 produces the one-cycle frame_rdy pulse. full_n stays 1 throughout.
- R7: Direct writes are ignored in continuous mode. Stream samples are refused in direct mode: s_ready is 0 and the memory is unchanged.
- R8: Changes to size_sel, ovl_sel and mode_cont take effect only at the edge that completes a frame, or at the first edge after reset. If the size changes at a boundary, or the mode changes at a boundary, nothing is copied and the next fill starts at address 0.
- R9: rd_data shows the word at rd_addr one clock cycle after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cont | input | 1 | 1 selects continuous streaming, 0 selects direct writes |
| size_sel | input | 2 | Frame length select |
| ovl_sel | input | 2 | Overlap fraction select |
| s_data | input | 16 | Streaming sample, two's complement |
| s_valid | input | 1 | Streaming sample present |
| s_ready | output | 1 | Block accepts a streaming sample |
| wr_n | input | 1 | Active-low direct write enable |
| wr_addr | input | 11 | Direct write address |
| wr_data | input | 16 | Direct write data |
| frame_rdy | output | 1 | One-cycle pulse when a frame is complete |
| full_n | output | 1 | Active-low buffer-full flag |
| rd_addr | input | 11 | Engine read address |
| rd_data | output | 16 | Engine read data, one cycle after rd_addr |

## Verification
The bench builds the block with its default 16-bit samples and 11-bit address, so the full 2K-word space is in use. This makes the largest size, with its 512-word copy from 0x600-0x7FF, reachable alongside the smallest frame. Running the 32-word frame at 75% overlap exercises a copy whose source and destination overlap. Mid-frame changes to size, overlap and mode show that each change waits for the boundary. Both directions of the mode switch are covered.

// File: rtl/ovl_in_buf.sv
module ovl_in_buf #(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_cont,
  input  logic [1:0]    size_sel,
  input  logic [1:0]    ovl_sel,
  input  logic [DW-1:0] s_data,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          wr_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          frame_rdy,
  output logic          full_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_FULL, S_COPY, S_DIRECT} st_t;

  function automatic logic [AW:0] f_words(input logic [1:0] sz);
    return (AW+1)'(DEPTH) >> (6 - 2 * int'(sz));
  endfunction

  function automatic logic [AW:0] f_keep(input logic [AW:0] w, input logic [1:0] ov);
    logic [AW:0] q;
    q = w >> 2;
    case (ov)
      2'd0:    return '0;
      2'd1:    return q;
      2'd2:    return q << 1;
      default: return (q << 1) + q;
    endcase
  endfunction

  st_t           st;
  logic [AW-1:0] ptr, cidx;
  logic [1:0]    act_sz, act_ov;
  logic          same_sz, nxt_cont, rdy_q;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  logic [AW:0]   fw, kw;
  logic [AW-1:0] src, wa;
  logic [DW-1:0] wd;
  logic          we, s_fire, d_fire, last_c, last_d;

  assign fw      = f_words(act_sz);
  assign kw      = f_keep(fw, act_ov);
  assign src     = AW'(fw - kw) + cidx;
  assign s_ready = (st == S_FILL);
  assign full_n  = !(st == S_FULL || st == S_COPY);
  assign s_fire  = s_valid && s_ready;
  assign d_fire  = !wr_n && (st == S_DIRECT);
  assign last_c  = s_fire && ({1'b0, ptr} == fw - 1'b1);
  assign last_d  = d_fire && ({1'b0, wr_addr} == fw - 1'b1);
  assign frame_rdy = rdy_q;
  assign rd_data = rd_q;

  always_comb begin
    we = 1'b0;
    wa = ptr;
    wd = s_data;
    if (st == S_COPY) begin
      we = 1'b1;
      wa = cidx;
      wd = mem[src];
    end else if (s_fire) begin
      we = 1'b1;
    end else if (d_fire) begin
      we = 1'b1;
      wa = wr_addr;
      wd = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      cidx     <= '0;
      act_sz   <= '0;
      act_ov   <= '0;
      same_sz  <= 1'b0;
      nxt_cont <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      rdy_q <= last_c || last_d;
      if (last_c || last_d) begin
        act_sz   <= size_sel;
        act_ov   <= ovl_sel;
        same_sz  <= (size_sel == act_sz);
        nxt_cont <= mode_cont;
      end
      case (st)
        S_IDLE: begin
          act_sz <= size_sel;
          act_ov <= ovl_sel;
          ptr    <= '0;
          st     <= mode_cont ? S_FILL : S_DIRECT;
        end
        S_FILL: begin
          if (last_c)      st  <= S_FULL;
          else if (s_fire) ptr <= ptr + 1'b1;
        end
        S_DIRECT: begin
          if (last_d && mode_cont) begin
            st  <= S_FILL;
            ptr <= '0;
          end
        end
        S_FULL: begin
          cidx <= '0;
          ptr  <= '0;
          if (nxt_cont && same_sz && kw != '0) st <= S_COPY;
          else if (nxt_cont)                    st <= S_FILL;
          else                                  st <= S_DIRECT;
        end
        S_COPY: begin
          if ({1'b0, cidx} == kw - 1'b1) begin
            st  <= S_FILL;
            ptr <= AW'(kw);
          end else begin
            cidx <= cidx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reset_flags_r1: assert property (@(posedge clk) !rst_n |=> (full_n && !frame_rdy && !s_ready));

  p_fill_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL) |-> ({1'b0, ptr} < fw));

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_rdy && !full_n) |=> !frame_rdy);

  p_copy_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COPY) |-> ({1'b0, cidx} < kw && $stable(act_sz)));

  p_full_starts_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_n) |-> frame_rdy);

  p_no_accept_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !s_ready);

  p_direct_not_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIRECT) |-> (full_n && !s_ready));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && $past(st) == S_FILL && !$past(last_c)) |-> ($stable(act_sz) && $stable(act_ov)));
endmodule

// File: tb/ovl_in_buf_bench.sv
module ovl_in_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_cont = 1'b1;
  logic [1:0]  size_sel = 2'd0;
  logic [1:0]  ovl_sel = 2'd0;
  logic [15:0] s_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        wr_n = 1'b1;
  logic [10:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        frame_rdy, full_n;
  logic [10:0] rd_addr = '0;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ovl_in_buf u_ovl_in_buf (
    .clk(clk), .rst_n(rst_n), .mode_cont(mode_cont), .size_sel(size_sel),
    .ovl_sel(ovl_sel), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data), .frame_rdy(frame_rdy),
    .full_n(full_n), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [15:0] va(int i); return 16'h1000 + 16'(i); endfunction
  function automatic logic [15:0] vb(int i); return 16'h2000 + 16'(i); endfunction
  function automatic logic [15:0] vc(int i); return 16'(i) ^ 16'hA5A5; endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v);
    s_valid = 1'b1;
    s_data = v;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic dwrite(input logic [10:0] a, input logic [15:0] d);
    wr_n = 1'b0; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic rdchk(input string req, input logic [10:0] a, input logic [15:0] exp);
    rd_addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic boundary(input int k);
    int n = 0;
    check("R3 frame_rdy high", frame_rdy, 1);
    check("R5 full_n low", full_n, 0);
    while (!full_n && n < 5000) begin
      if (s_ready) check("R5 s_ready while full", s_ready, 0);
      n++;
      @(negedge clk);
    end
    check("R5 full cycles", n, k + 1);
    check("R3 pulse ended", frame_rdy, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 full_n", full_n, 1);
    check("R1 frame_rdy", frame_rdy, 0);
    check("R1 s_ready", s_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_fill_overlap75;
    for (int i = 0; i < 32; i++) begin
      if (i % 5 == 2) @(negedge clk);
      push(va(i));
      if (i == 9) ovl_sel = 2'd3;
      if (i < 31 && frame_rdy) check("R3 early pulse", frame_rdy, 0);
    end
    boundary(24);
    for (int i = 0; i < 24; i++) rdchk("R4 copied word", 11'(i), va(i + 8));
    for (int i = 24; i < 32; i++) rdchk("R2 kept word", 11'(i), va(i));
  endtask

  task automatic t_resize;
    push(vb(0));
    dwrite(11'd3, 16'hDEAD);
    rdchk("R7 direct ignored", 11'd3, va(11));
    for (int i = 1; i < 8; i++) begin
      if (i == 4) begin size_sel = 2'd3; ovl_sel = 2'd1; end
      push(vb(i));
    end
    boundary(0);
    for (int i = 0; i < 8; i++) rdchk("R8 fill from K", 11'(24 + i), vb(i));
  endtask

  task automatic t_big_copy;
    for (int i = 0; i < 2048; i++) push(vc(i));
    boundary(512);
    rdchk("R4 0x000", 11'h000, vc(11'h600));
    rdchk("R4 0x100", 11'h100, vc(11'h700));
    rdchk("R4 0x1FF", 11'h1FF, vc(11'h7FF));
    push(16'h7777);
    rdchk("R4 resume 0x200", 11'h200, 16'h7777);
    rdchk("R4 below intact", 11'h1FF, vc(11'h7FF));
    mode_cont = 1'b0; size_sel = 2'd0; ovl_sel = 2'd0;
    for (int i = 1; i < 1536; i++) push(16'h3000 + 16'(i));
    boundary(0);
  endtask

  task automatic t_direct;
    check("R7 s_ready direct", s_ready, 0);
    s_valid = 1'b1; s_data = 16'hBAD0;
    repeat (3) @(negedge clk);
    check("R7 s_ready still", s_ready, 0);
    s_valid = 1'b0;
    rdchk("R7 stream ignored", 11'h000, vc(11'h600));
    dwrite(11'd5, 16'h0BEE);
    check("R6 no pulse", frame_rdy, 0);
    rdchk("R9 read direct", 11'd5, 16'h0BEE);
    dwrite(11'd31, 16'h1234);
    check("R6 pulse at top", frame_rdy, 1);
    check("R6 full_n high", full_n, 1);
    @(negedge clk);
    check("R6 pulse one cycle", frame_rdy, 0);
    rdchk("R9 read top", 11'd31, 16'h1234);
  endtask

  initial begin
    t_reset;
    t_fill_overlap75;
    t_resize;
    t_big_copy;
    t_direct;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule